// File: doc/BRIEF.md
# Exception Priority and Entry Unit

This unit sits beside the execute stage of a simple 32-bit processor. Each cycle it looks at up to seven exception sources: a reset request, a data abort, two level-sensitive active-low interrupt pins (a fast one and a normal one), a prefetch abort, a software interrupt and an undefined-instruction flag. It picks the most urgent source and, on the next clock edge, presents a redirect strobe, the vector fetch address, a code for the chosen exception and the status word the core must adopt.

In the same edge it saves the interrupted context into the banked registers of the target mode: the old status word goes to the saved-status register and the return address goes to the link register. The core reads a bank back through a mode-select input when it later returns from the handler. Abort-type sources are flagged by the execute stage only once the faulting instruction reaches it. The core feeds the new status word back as the current one after each redirect.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low and just after it rises, `redirect` is 0, `exc_kind` is 0, `new_status` is 32'h0000_00D3, `vec_addr` is 0 and every bank reads back as zero.
- R2: When several sources are pending, the winner is, from highest to lowest: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, then software interrupt and undefined instruction. If both of the last two are flagged, the software interrupt wins.
- R3: `nfiq` is active low and is recognised only while bit 6 (fast disable) of `cur_status` is 0. `nirq` is active low and is recognised only while bit 7 (normal disable) is 0.
- R4: A reset request is taken whatever the disable bits hold. The status becomes exactly 32'h0000_00D3 (supervisor mode 5'b10011, bits 7 and 6 set), the vector is 0x00, and no bank is written.
- R5: Fast-interrupt entry sets mode 5'b10001 in bits [4:0], sets bits 7 and 6, and vectors to 0x1C.
- R6: Normal-interrupt entry sets mode 5'b10010 and bit 7, keeps bit 6, and vectors to 0x18.
- R7: Data-abort entry sets mode 5'b10111 and bit 7, keeps bit 6, and vectors to 0x10. A fast interrupt that is still pending is then taken on the following cycle once the new status is fed back.
- R8: Prefetch abort enters mode 5'b10111 (vector 0x0C). Software interrupt enters supervisor mode 5'b10011 (vector 0x08). Undefined instruction enters mode 5'b11011 (vector 0x04). Each of these sets bit 7 and keeps bit 6.
- R9: On every entry other than reset, the bank of the target mode stores `cur_status` as its saved status and `cur_pc + 4` as its link. Other banks keep their contents. `rd_mode` selects a bank by mode encoding, and an encoding that has no bank reads zero.
- R10: Outputs are registered. `redirect` rises one cycle after a request is seen. `exc_kind` uses 1 reset, 2 data abort, 3 fast interrupt, 4 normal interrupt, 5 prefetch abort, 6 software interrupt, 7 undefined. With no request recognised, `redirect` is 0 and the other outputs hold.
- R11: On non-reset entries, every status bit other than [4:0], 6 and 7 is copied unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| reset_req | input | 1 | Reset exception request |
| dabt_req | input | 1 | Data abort flag from execute |
| nfiq | input | 1 | Fast interrupt pin, active low |
| nirq | input | 1 | Normal interrupt pin, active low |
| pabt_req | input | 1 | Prefetch abort flag from execute |
| swi_req | input | 1 | Software interrupt flag from execute |
| und_req | input | 1 | Undefined instruction flag from execute |
| cur_status | input | 32 | Current status word |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| rd_mode | input | 5 | Mode encoding selecting a bank to read |
| redirect | output | 1 | Fetch redirect strobe |
| exc_kind | output | 3 | Code of the exception taken |
| new_status | output | 32 | Status word after entry |
| vec_addr | output | 32 | Vector fetch address |
| rd_saved | output | 32 | Saved status of the selected bank |
| rd_link | output | 32 | Link value of the selected bank |

## Verification
Arbitration and masking can fall in the same cycle. A fast-interrupt pin may be low together with a data abort, or while its own disable bit is set, and the normal pin may compete in that same cycle. The bench drives such combinations from its vector table and judges the winner, the vector and every status bit one edge later. It also covers entry followed at once by a second entry. A data abort is taken, its status is fed back, and the still-low fast pin must then win. The bench then checks that the abort bank and the fast bank each hold their own context.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

    localparam int MODE_W     = 5;
    localparam int I_BIT      = 7;
    localparam int F_BIT      = 6;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = 3;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    localparam logic [7:0] RESET_LOW = {2'b11, 1'b0, MODE_SVC};

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_RESET = 3'd1,
        EXC_DABT  = 3'd2,
        EXC_FIQ   = 3'd3,
        EXC_IRQ   = 3'd4,
        EXC_PABT  = 3'd5,
        EXC_SWI   = 3'd6,
        EXC_UND   = 3'd7
    } exc_kind_e;

    function automatic logic [7:0] vec_offset(exc_kind_e k);
        logic [7:0] v;
        case (k)
            EXC_UND:  v = 8'h04;
            EXC_SWI:  v = 8'h08;
            EXC_PABT: v = 8'h0C;
            EXC_DABT: v = 8'h10;
            EXC_IRQ:  v = 8'h18;
            EXC_FIQ:  v = 8'h1C;
            default:  v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [MODE_W-1:0] target_mode(exc_kind_e k);
        logic [MODE_W-1:0] m;
        case (k)
            EXC_FIQ:            m = MODE_FIQ;
            EXC_IRQ:            m = MODE_IRQ;
            EXC_DABT, EXC_PABT: m = MODE_ABT;
            EXC_UND:            m = MODE_UND;
            default:            m = MODE_SVC;
        endcase
        return m;
    endfunction

    function automatic logic [BANK_IDX_W-1:0] bank_of_mode(logic [MODE_W-1:0] m);
        logic [BANK_IDX_W-1:0] b;
        case (m)
            MODE_FIQ: b = 3'd0;
            MODE_IRQ: b = 3'd1;
            MODE_SVC: b = 3'd2;
            MODE_ABT: b = 3'd3;
            MODE_UND: b = 3'd4;
            default:  b = 3'd7;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
`timescale 1ns/1ps
module exc_prio_arb
    import exc_pkg::*;
(
    input  logic      reset_req,
    input  logic      dabt_req,
    input  logic      nfiq,
    input  logic      nirq,
    input  logic      pabt_req,
    input  logic      swi_req,
    input  logic      und_req,
    input  logic      fiq_off,
    input  logic      irq_off,
    output exc_kind_e sel
);
    localparam int NSRC = 7;

    // bit i corresponds to exception code i+1; lower index wins
    logic [NSRC-1:0] pend;

    always_comb begin
        pend = {und_req, swi_req, pabt_req,
                ~nirq & ~irq_off,
                ~nfiq & ~fiq_off,
                dabt_req, reset_req};
    end

    always_comb begin
        sel = EXC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel = exc_kind_e'(3'(i + 1));
            end
        end
    end
endmodule

// File: rtl/exc_status_gen.sv
`timescale 1ns/1ps
module exc_status_gen
    import exc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cur_status,
    input  exc_kind_e         kind,
    output logic [DATA_W-1:0] next_status
);
    always_comb begin
        next_status = cur_status;
        if (kind == EXC_RESET) begin
            next_status = DATA_W'(RESET_LOW);
        end else if (kind != EXC_NONE) begin
            next_status[MODE_W-1:0] = target_mode(kind);
            next_status[I_BIT]      = 1'b1;
            if (kind == EXC_FIQ) begin
                next_status[F_BIT] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_bank_regs.sv
`timescale 1ns/1ps
module exc_bank_regs #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 5,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_saved,
    input  logic [DATA_W-1:0] wr_link,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_saved,
    output logic [DATA_W-1:0] rd_link
);
    typedef struct packed {
        logic [DATA_W-1:0] saved;
        logic [DATA_W-1:0] link;
    } bank_t;

    bank_t bank_d [NUM_BANKS];
    bank_t bank_q [NUM_BANKS];

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            bank_d[i] = bank_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                bank_d[i].saved = wr_saved;
                bank_d[i].link  = wr_link;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                bank_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    always_comb begin
        rd_saved = '0;
        rd_link  = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_saved = bank_q[i].saved;
                rd_link  = bank_q[i].link;
            end
        end
    end
endmodule

// File: rtl/exc_entry_unit.sv
`timescale 1ns/1ps
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter logic [31:0]     VEC_BASE = 32'h0,
    parameter int              LINK_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              dabt_req,
    input  logic              nfiq,
    input  logic              nirq,
    input  logic              pabt_req,
    input  logic              swi_req,
    input  logic              und_req,
    input  logic [DATA_W-1:0] cur_status,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [4:0]        rd_mode,
    output logic              redirect,
    output logic [2:0]        exc_kind,
    output logic [DATA_W-1:0] new_status,
    output logic [DATA_W-1:0] vec_addr,
    output logic [DATA_W-1:0] rd_saved,
    output logic [DATA_W-1:0] rd_link
);
    localparam logic [DATA_W-1:0] RST_STATUS = DATA_W'(RESET_LOW);
    localparam logic [DATA_W-1:0] BASE       = DATA_W'(VEC_BASE);

    typedef struct packed {
        logic              redirect;
        exc_kind_e         kind;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] vec;
    } entry_t;

    entry_t            st_d, st_q;
    exc_kind_e         sel;
    logic [DATA_W-1:0] gen_status;
    logic              bank_wr;
    logic [BANK_IDX_W-1:0] bank_wr_idx;

    exc_prio_arb u_arb (
        .reset_req (reset_req),
        .dabt_req  (dabt_req),
        .nfiq      (nfiq),
        .nirq      (nirq),
        .pabt_req  (pabt_req),
        .swi_req   (swi_req),
        .und_req   (und_req),
        .fiq_off   (cur_status[F_BIT]),
        .irq_off   (cur_status[I_BIT]),
        .sel       (sel)
    );

    exc_status_gen #(.DATA_W(DATA_W)) u_stat (
        .cur_status  (cur_status),
        .kind        (sel),
        .next_status (gen_status)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = (sel != EXC_NONE);
        bank_wr       = (sel != EXC_NONE) && (sel != EXC_RESET);
        bank_wr_idx   = bank_of_mode(target_mode(sel));
        if (sel != EXC_NONE) begin
            st_d.kind   = sel;
            st_d.status = gen_status;
            st_d.vec    = BASE + DATA_W'(vec_offset(sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.redirect <= 1'b0;
            st_q.kind     <= EXC_NONE;
            st_q.status   <= RST_STATUS;
            st_q.vec      <= BASE;
        end else begin
            st_q <= st_d;
        end
    end

    exc_bank_regs #(
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (BANK_IDX_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_wr),
        .wr_idx   (bank_wr_idx),
        .wr_saved (cur_status),
        .wr_link  (cur_pc + DATA_W'(LINK_OFS)),
        .rd_idx   (bank_of_mode(rd_mode)),
        .rd_saved (rd_saved),
        .rd_link  (rd_link)
    );

    assign redirect   = st_q.redirect;
    assign exc_kind   = st_q.kind;
    assign new_status = st_q.status;
    assign vec_addr   = st_q.vec;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic              dabt_req,
    input logic              nfiq,
    input logic              nirq,
    input logic              pabt_req,
    input logic              swi_req,
    input logic              und_req,
    input logic [DATA_W-1:0] cur_status,
    input logic              redirect,
    input logic [2:0]        exc_kind,
    input logic [DATA_W-1:0] new_status
);
    // R4
    reset_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (redirect && exc_kind == 3'd1 && new_status[7:0] == 8'hD3));

    // R2
    dabt_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dabt_req && !reset_req) |=> (redirect && exc_kind == 3'd2));

    // R3
    fiq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && exc_kind == 3'd3) |-> (!$past(cur_status[6]) && !$past(nfiq)));

    // R5
    fiq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && exc_kind == 3'd3) |-> (new_status[7:6] == 2'b11 && new_status[4:0] == 5'b10001));

    // R6
    irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && exc_kind == 3'd4) |->
        (new_status[7] && new_status[6] == $past(cur_status[6]) && new_status[4:0] == 5'b10010));

    // R7
    dabt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && exc_kind == 3'd2) |->
        (new_status[6] == $past(cur_status[6]) && new_status[4:0] == 5'b10111));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_req && !dabt_req && nfiq && nirq && !pabt_req && !swi_req && !und_req) |=> !redirect);
endmodule

bind exc_entry_unit exc_entry_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_req  (reset_req),
    .dabt_req   (dabt_req),
    .nfiq       (nfiq),
    .nirq       (nirq),
    .pabt_req   (pabt_req),
    .swi_req    (swi_req),
    .und_req    (und_req),
    .cur_status (cur_status),
    .redirect   (redirect),
    .exc_kind   (exc_kind),
    .new_status (new_status)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reset_req, dabt_req, nfiq, nirq, pabt_req, swi_req, und_req;
    logic [31:0] cur_status, cur_pc;
    logic [4:0]  rd_mode;
    logic        redirect;
    logic [2:0]  exc_kind;
    logic [31:0] new_status, vec_addr, rd_saved, rd_link;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_unit u_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dabt_req(dabt_req),
        .nfiq(nfiq), .nirq(nirq), .pabt_req(pabt_req), .swi_req(swi_req),
        .und_req(und_req), .cur_status(cur_status), .cur_pc(cur_pc),
        .rd_mode(rd_mode), .redirect(redirect), .exc_kind(exc_kind),
        .new_status(new_status), .vec_addr(vec_addr),
        .rd_saved(rd_saved), .rd_link(rd_link)
    );

    // stim = {reset, dabt, nfiq, nirq, pabt, swi, und}
    typedef struct packed {
        logic [6:0] stim;
        logic [7:0] st;
        logic [2:0] kind;
        logic [7:0] nst;
        logic [7:0] vec;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{7'b0011000, 8'h10, 3'd0, 8'h00, 8'h00},
        '{7'b0010000, 8'h10, 3'd4, 8'h92, 8'h18},
        '{7'b0001000, 8'h10, 3'd3, 8'hD1, 8'h1C},
        '{7'b0000000, 8'h10, 3'd3, 8'hD1, 8'h1C},
        '{7'b0100000, 8'h10, 3'd2, 8'h97, 8'h10},
        '{7'b0000000, 8'h50, 3'd4, 8'hD2, 8'h18},
        '{7'b0000100, 8'hD0, 3'd5, 8'hD7, 8'h0C},
        '{7'b0011010, 8'h10, 3'd6, 8'h93, 8'h08},
        '{7'b0011001, 8'h30, 3'd7, 8'hBB, 8'h04},
        '{7'b1100111, 8'h10, 3'd1, 8'hD3, 8'h00},
        '{7'b0011110, 8'h10, 3'd5, 8'h97, 8'h0C},
        '{7'b0010000, 8'h90, 3'd0, 8'h00, 8'h00}
    };

    localparam logic [6:0]  IDLE = 7'b0011000;
    localparam logic [23:0] HI   = 24'hF00000;

    function automatic string tag_of(logic [2:0] k);
        case (k)
            3'd0: return "R10 R3";
            3'd1: return "R4";
            3'd2: return "R7 R2";
            3'd3: return "R5 R2";
            3'd4: return "R6 R3";
            default: return "R8 R2";
        endcase
    endfunction

    function automatic logic [4:0] mode_of(logic [2:0] k);
        case (k)
            3'd2, 3'd5: return 5'b10111;
            3'd3: return 5'b10001;
            3'd4: return 5'b10010;
            3'd7: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [6:0] s, logic [31:0] st, logic [31:0] pc);
        {reset_req, dabt_req, nfiq, nirq, pabt_req, swi_req, und_req} = s;
        cur_status = st;
        cur_pc     = pc;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        rd_mode = 5'b10001;
        drive(IDLE, 32'h10, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 redirect", 32'(redirect), 32'd0);
        chk("R1 kind", 32'(exc_kind), 32'd0);
        chk("R1 status", new_status, 32'h0000_00D3);
        chk("R1 vec", vec_addr, 32'h0);
        chk("R1 bank saved", rd_saved, 32'h0);
        chk("R1 bank link", rd_link, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].stim, {HI, VECS[i].st}, 32'h1000 + 32'(i * 16));
            @(negedge clk);
            chk({tag_of(VECS[i].kind), " redirect"}, 32'(redirect), 32'(VECS[i].kind != 3'd0));
            if (VECS[i].kind != 3'd0) begin
                chk({tag_of(VECS[i].kind), " kind"}, 32'(exc_kind), 32'(VECS[i].kind));
                chk({tag_of(VECS[i].kind), " vec"}, vec_addr, 32'(VECS[i].vec));
                if (VECS[i].kind == 3'd1)
                    chk("R4 status", new_status, 32'h0000_00D3);
                else
                    chk({tag_of(VECS[i].kind), " R11 status"}, new_status, {HI, VECS[i].nst});
            end
            if (VECS[i].kind > 3'd1) begin
                rd_mode = mode_of(VECS[i].kind);
                #1;
                chk("R9 saved", rd_saved, {HI, VECS[i].st});
                chk("R9 link", rd_link, 32'h1000 + 32'(i * 16) + 32'd4);
            end
        end

        // R10 outputs hold after an idle vector (last entry was vector 10)
        chk("R10 hold status", new_status, {HI, 8'h97});
        chk("R10 hold vec", vec_addr, 32'h0C);
        // R4 reset request left the supervisor bank as written by vector 7
        rd_mode = 5'b10011;
        #1;
        chk("R4 svc saved kept", rd_saved, {HI, 8'h10});
        chk("R4 svc link kept", rd_link, 32'h1074);
        rd_mode = 5'b10000;
        #1;
        chk("R9 unmapped saved", rd_saved, 32'h0);

        // R7 data abort with fast pin low, then fast interrupt next cycle
        @(negedge clk);
        drive(7'b0100000, 32'h10, 32'h2000);
        @(negedge clk);
        chk("R7 abort kind", 32'(exc_kind), 32'd2);
        chk("R7 abort status", new_status, 32'h97);
        drive(7'b0001000, new_status, 32'h2004);
        @(negedge clk);
        chk("R7 fiq follows", 32'(exc_kind), 32'd3);
        chk("R7 fiq status", new_status, 32'hD1);
        chk("R7 fiq vec", vec_addr, 32'h1C);
        drive(IDLE, new_status, 32'h2008);
        rd_mode = 5'b10111;
        #1;
        chk("R9 abort bank", rd_saved, 32'h10);
        chk("R9 abort link", rd_link, 32'h2004);
        rd_mode = 5'b10001;
        #1;
        chk("R9 fiq bank", rd_saved, 32'h97);
        chk("R9 fiq link", rd_link, 32'h2008);
        rd_mode = 5'b10010;
        #1;
        chk("R9 irq bank untouched", rd_saved, {HI, 8'h50});
        chk("R9 irq link untouched", rd_link, 32'h1054);
        @(negedge clk);
        chk("R10 idle no redirect", 32'(redirect), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule